// File: doc/BRIEF.md
# Link Pulse Generator

The block drives one serial pulse line toward a twisted-pair line driver. It either emits a lone link-integrity pulse once per frame, or emits a burst that carries a 16-bit code word. In a burst, a clock pulse opens each of 17 equally spaced slots. A data pulse is placed a fixed offset after a clock pulse when the matching word bit is 1, and is left out when the bit is 0. Bursts and single pulses both repeat with the same frame period.

All timing values are parameters counted in reference-clock cycles. Silicon uses the real durations: a 100 ns pulse, 125 us between clock pulses, a 62 us data offset and a 16 ms frame. A simulation can use small values. The mode and the code word are captured when a frame begins. Dropping the enable lets any pulse already in flight end at full width, then keeps the line low. The next enable starts a new frame at once.

Top module: `link_pulse_gen`

## Requirements
- R1: While `rst` is high, `pulse_out` is low on the next cycle. After reset, no pulse appears until `en` is seen high.
- R2: Every pulse on `pulse_out` is high for exactly `PULSE_CYC` consecutive cycles.
- R3: With `mode_burst` = 0, exactly one pulse is sent per frame, starting on the frame's first edge.
- R4: With `mode_burst` = 1, a frame carries 17 clock pulses. They start at frame offsets k·`CLK_SPACE_CYC` for k = 0..16, counted from the frame's first edge.
- R5: With `mode_burst` = 1, bit k of the code word (bit 0 first, bit 15 last) produces a pulse starting at offset k·`CLK_SPACE_CYC` + `DATA_OFS_CYC` when it is 1. When it is 0, no pulse is sent there.
- R6: While `en` stays high, frames follow each other every `FRAME_CYC` cycles without a gap.
- R7: `mode_burst` and `code_word` are sampled on the first edge of each frame. A change in mid-frame only alters the following frame.
- R8: When `en` falls, a pulse already begun still lasts its full width. `pulse_out` then stays low for as long as `en` is low.
- R9: The first edge on which `en` is seen high starts a new frame, with the pulse at offset 0 beginning on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable |
| mode_burst | input | 1 | 0: single pulse per frame, 1: coded burst per frame |
| code_word | input | 16 | Word carried by the burst, bit 0 sent first |
| pulse_out | output | 1 | Registered pulse line to the driver |

## Verification
The assertions on pulse width and on triggers never overlapping rely on the spacing parameters leaving room between slots. The data offset must exceed the pulse width, the rest of each slot must exceed it as well, and the frame must outlast the burst plus one pulse. Parameter checks at elaboration guard this. The bench uses a pulse of 2 cycles, a slot of 10 cycles, a data offset of 5 and a frame of 200, all inside those limits. The bench changes `mode_burst`, `code_word` and `en` only on falling clock edges. Every input change therefore meets a clean rising edge, which is the sampling model the frame-start capture assumes.

// File: rtl/lpg_pkg.sv
package lpg_pkg;
  typedef enum logic {
    LP_SINGLE = 1'b0,
    LP_BURST  = 1'b1
  } lp_mode_e;

  localparam int unsigned LP_WORD_BITS = 16;
endpackage

// File: rtl/lpg_frame_timer.sv
module lpg_frame_timer #(
  parameter int unsigned FRAME_CYC = 800000,
  localparam int unsigned POS_W = $clog2(FRAME_CYC)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic frame_first,
  output logic frame_last
);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(FRAME_CYC - 1);

  logic [POS_W-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pos_q <= '0;
    end else if (pos_q == POS_LAST) begin
      pos_q <= '0;
    end else begin
      pos_q <= pos_q + 1'b1;
    end
  end

  assign frame_first = run && (pos_q == '0);
  assign frame_last  = run && (pos_q == POS_LAST);

  // R6
  frame_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_last && run) |=> (pos_q == '0));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (pos_q == '0));
endmodule

// File: rtl/lpg_burst_seq.sv
module lpg_burst_seq
  import lpg_pkg::*;
#(
  parameter int unsigned CLK_SPACE_CYC = 6250,
  parameter int unsigned DATA_OFS_CYC  = 3100,
  parameter int unsigned WORD_BITS     = LP_WORD_BITS,
  localparam int unsigned SLOT_W = $clog2(CLK_SPACE_CYC),
  localparam int unsigned IDX_W  = $clog2(WORD_BITS + 2),
  localparam int unsigned BIT_W  = $clog2(WORD_BITS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run,
  input  logic                 frame_first,
  input  logic                 frame_last,
  input  lp_mode_e             mode_in,
  input  logic [WORD_BITS-1:0] word_in,
  output logic                 clk_fire,
  output logic                 data_fire
);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(CLK_SPACE_CYC - 1);
  localparam logic [SLOT_W-1:0] DATA_AT   = SLOT_W'(DATA_OFS_CYC);
  localparam logic [IDX_W-1:0]  IDX_BITS  = IDX_W'(WORD_BITS);

  logic [SLOT_W-1:0]    slot_q;
  logic [IDX_W-1:0]     idx_q;
  logic [WORD_BITS-1:0] word_q;
  lp_mode_e             mode_q;
  logic                 bit_set;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      slot_q <= '0;
      idx_q  <= '0;
    end else if (frame_last) begin
      slot_q <= '0;
      idx_q  <= '0;
    end else if (idx_q <= IDX_BITS) begin
      if (slot_q == SLOT_LAST) begin
        slot_q <= '0;
        idx_q  <= idx_q + 1'b1;
      end else begin
        slot_q <= slot_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      word_q <= '0;
      mode_q <= LP_SINGLE;
    end else if (frame_first) begin
      word_q <= word_in;
      mode_q <= mode_in;
    end
  end

  assign bit_set = word_q[idx_q[BIT_W-1:0]];

  always_comb begin
    clk_fire  = frame_first;
    data_fire = 1'b0;
    if (run && !frame_first && mode_q == LP_BURST) begin
      if (slot_q == '0 && idx_q != '0 && idx_q <= IDX_BITS) begin
        clk_fire = 1'b1;
      end
      if (slot_q == DATA_AT && idx_q < IDX_BITS && bit_set) begin
        data_fire = 1'b1;
      end
    end
  end

  // R5
  fire_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(clk_fire && data_fire));

  // R3
  single_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == LP_SINGLE && !frame_first) |-> !(clk_fire || data_fire));
endmodule

// File: rtl/lpg_pulse_shaper.sv
module lpg_pulse_shaper #(
  parameter int unsigned PULSE_CYC = 5,
  localparam int unsigned CNT_W = $clog2(PULSE_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic pulse
);
  logic [CNT_W-1:0] left_q;
  logic             pulse_q;
  logic [CNT_W:0]   hi_len_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q <= 1'b0;
      left_q  <= '0;
    end else if (fire) begin
      pulse_q <= 1'b1;
      left_q  <= CNT_W'(PULSE_CYC - 1);
    end else if (pulse_q) begin
      if (left_q == '0) begin
        pulse_q <= 1'b0;
      end else begin
        left_q <= left_q - 1'b1;
      end
    end
  end

  assign pulse = pulse_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_len_q <= '0;
    end else if (pulse_q) begin
      hi_len_q <= hi_len_q + 1'b1;
    end else begin
      hi_len_q <= '0;
    end
  end

  // R2
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pulse_q) |-> (hi_len_q == (CNT_W + 1)'(PULSE_CYC)));

  // R2
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    fire |-> !pulse_q);
endmodule

// File: rtl/link_pulse_gen.sv
module link_pulse_gen
  import lpg_pkg::*;
#(
  parameter int unsigned PULSE_CYC     = 5,
  parameter int unsigned CLK_SPACE_CYC = 6250,
  parameter int unsigned DATA_OFS_CYC  = 3100,
  parameter int unsigned FRAME_CYC     = 800000,
  parameter int unsigned WORD_BITS     = LP_WORD_BITS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 mode_burst,
  input  logic [WORD_BITS-1:0] code_word,
  output logic                 pulse_out
);
  logic     frame_first;
  logic     frame_last;
  logic     clk_fire;
  logic     data_fire;
  lp_mode_e mode_sel;

  assign mode_sel = mode_burst ? LP_BURST : LP_SINGLE;

  initial begin
    param_ofs_chk: assert (DATA_OFS_CYC > PULSE_CYC);
    param_slot_chk: assert (CLK_SPACE_CYC - DATA_OFS_CYC > PULSE_CYC);
    param_frame_chk: assert (FRAME_CYC > WORD_BITS * CLK_SPACE_CYC + PULSE_CYC + 1);
  end

  lpg_frame_timer #(
    .FRAME_CYC(FRAME_CYC)
  ) u_timer (
    .clk        (clk),
    .rst        (rst),
    .run        (en),
    .frame_first(frame_first),
    .frame_last (frame_last)
  );

  lpg_burst_seq #(
    .CLK_SPACE_CYC(CLK_SPACE_CYC),
    .DATA_OFS_CYC (DATA_OFS_CYC),
    .WORD_BITS    (WORD_BITS)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .run        (en),
    .frame_first(frame_first),
    .frame_last (frame_last),
    .mode_in    (mode_sel),
    .word_in    (code_word),
    .clk_fire   (clk_fire),
    .data_fire  (data_fire)
  );

  lpg_pulse_shaper #(
    .PULSE_CYC(PULSE_CYC)
  ) u_shaper (
    .clk  (clk),
    .rst  (rst),
    .fire (clk_fire || data_fire),
    .pulse(pulse_out)
  );

  // R1
  reset_low_chk: assert property (@(posedge clk)
    rst |=> !pulse_out);

  // R8
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !pulse_out) |=> !pulse_out);

  // R9
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !$past(en) && !$past(rst)) |=> pulse_out);
endmodule

// File: tb/link_pulse_gen_bench.sv
module link_pulse_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int L_PW  = 2;
  localparam int L_CSP = 10;
  localparam int L_DOF = 5;
  localparam int L_FRM = 200;
  localparam int NBITS = 16;
  localparam int NVEC  = 5;

  // {mode_burst, code_word}
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b0, 16'hA5A5},
    {1'b1, 16'h0000},
    {1'b1, 16'hFFFF},
    {1'b1, 16'h8001},
    {1'b1, 16'h1234}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        mode_burst = 1'b0;
  logic [15:0] code_word = '0;
  logic        pulse_out;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  link_pulse_gen #(
    .PULSE_CYC    (L_PW),
    .CLK_SPACE_CYC(L_CSP),
    .DATA_OFS_CYC (L_DOF),
    .FRAME_CYC    (L_FRM),
    .WORD_BITS    (NBITS)
  ) u_link_pulse_gen (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .mode_burst(mode_burst),
    .code_word (code_word),
    .pulse_out (pulse_out)
  );

  // Expected line level at a frame offset, from R2..R5.
  function automatic logic exp_level(input logic burst, input logic [15:0] w, input int off);
    logic hit = 1'b0;
    if (off >= 0 && off < L_PW) hit = 1'b1;
    if (burst) begin
      for (int k = 1; k <= NBITS; k++)
        if (off - k * L_CSP >= 0 && off - k * L_CSP < L_PW) hit = 1'b1;
      for (int k = 0; k < NBITS; k++)
        if (w[k] && off - (k * L_CSP + L_DOF) >= 0 && off - (k * L_CSP + L_DOF) < L_PW)
          hit = 1'b1;
    end
    return hit;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    en  = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // Runs frames; after sample chg_at, mode/word switch to the second set.
  task automatic run_frames(input logic b0, input logic [15:0] w0,
                            input logic b1, input logic [15:0] w1,
                            input int chg_at, input int nfr, input string tag);
    int bad;
    int first_j;
    logic first_exp;
    mode_burst = b0;
    code_word  = w0;
    en         = 1'b1;
    for (int f = 0; f < nfr; f++) begin
      bad = 0;
      first_j = -1;
      first_exp = 1'b0;
      for (int o = 0; o < L_FRM; o++) begin
        logic e;
        int j;
        j = f * L_FRM + o;
        @(negedge clk);
        e = (f == 0 || chg_at >= L_FRM) ? exp_level(b0, w0, o) : exp_level(b1, w1, o);
        if (pulse_out !== e) begin
          bad++;
          if (first_j < 0) begin
            first_j = o;
            first_exp = e;
          end
        end
        if (j == chg_at) begin
          mode_burst = b1;
          code_word  = w1;
        end
      end
      check(bad == 0, $sformatf("%s frame %0d offset %0d", tag, f, first_j),
            (first_j < 0) ? 0 : int'(!first_exp), (first_j < 0) ? 0 : int'(first_exp));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    int seen;
    // R1: low during reset and while not yet enabled
    do_reset();
    check(pulse_out == 1'b0, "R1 reset state", pulse_out, 0);
    seen = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (pulse_out) seen++;
    end
    check(seen == 0, "R1 R8 idle after reset", seen, 0);

    // Table walk: R2 R3 R4 R5 R6 R9
    for (int v = 0; v < NVEC; v++) begin
      do_reset();
      run_frames(VEC[v][16], VEC[v][15:0], VEC[v][16], VEC[v][15:0], L_FRM * 3, 2,
                 $sformatf("R2 R3 R4 R5 R6 R9 vec%0d", v));
    end

    // R7: word change in mid-burst lands on the next frame
    do_reset();
    run_frames(1'b1, 16'h00F0, 1'b1, 16'h0F00, 30, 2, "R7 word change");

    // R7: mode change in mid-frame lands on the next frame
    do_reset();
    run_frames(1'b0, 16'hFFFF, 1'b1, 16'h5555, 30, 2, "R7 mode change");

    // R8: disable on the first pulse cycle, pulse keeps full width then line stays low
    do_reset();
    mode_burst = 1'b1;
    code_word  = 16'hFFFF;
    en         = 1'b1;
    @(negedge clk);
    en = 1'b0;
    seen = pulse_out ? 1 : 0;
    for (int i = 1; i < 2 * L_FRM; i++) begin
      @(negedge clk);
      if (pulse_out) seen++;
      if (i >= L_PW && pulse_out) begin
        check(1'b0, "R8 line low while disabled", 1, 0);
        break;
      end
    end
    check(seen == L_PW, "R8 in-flight pulse width", seen, L_PW);

    // R9: re-enable starts a fresh frame on the first edge
    run_frames(1'b1, 16'hFFFF, 1'b1, 16'hFFFF, L_FRM * 3, 1, "R9 re-enable");

    // R8: disable in mid-burst between pulses, then nothing
    do_reset();
    mode_burst = 1'b1;
    code_word  = 16'hFFFF;
    en         = 1'b1;
    repeat (23) @(negedge clk);
    en = 1'b0;
    seen = 0;
    for (int i = 0; i < L_FRM; i++) begin
      @(negedge clk);
      if (pulse_out) seen++;
    end
    check(seen == 0, "R8 disabled between pulses", seen, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule